// File: doc/BRIEF.md
# Clocked Synchronous Serial Shifter

This block moves one serial frame per software request. A frame is either one byte or two bytes. Bits leave on the serial output least significant bit first, and bits arriving on the serial input are gathered into the same data registers, so when the frame ends those registers hold the received word. The serial clock comes from one of two places, picked by a 4-bit select field. The block can make it from the system clock with a power-of-two divider, or it can take it from the clock pin when an outside device drives that pin.

Software sets up the control register, loads the data bytes and then sets the start bit. The block runs exactly one frame, sets a completion flag that also drives the interrupt line, and returns to idle. When it is idle the serial output holds the last bit that was sent, and software can force that level. With the external clock, any clock pulse that arrives while no frame is running does not shift data; it sets an overrun flag instead. Writing the control register at any time stops the shifter and clears its state.

Top module: `ssx_top`

## Requirements
- R1: Control bit 6 sets the frame length: 0 gives 8 clock pulses per frame and 1 gives 16.
- R2: Transmit bits leave least significant bit first. In a 16-bit frame the low data byte (address 2) goes out before the high data byte (address 3). In an 8-bit frame the high byte is neither sent nor changed.
- R3: Each received bit enters at the top of the active word and shifts down. After the frame, the first bit received sits in bit 0 of the low byte.
- R4: A frame starts only when a status write (address 1) has bit 7 set. Status bit 7 reads 1 while the frame runs and clears itself when the frame ends. With no start, the serial clock stays still.
- R5: Clock-select codes 0 to 7 (control bits 3:0) select the internal clock. The output clock idles high, is driven (sck_oe high) only during a frame, and holds each level for 2^code system clocks.
- R6: The serial output changes after a falling clock edge. The serial input is sampled on the rising edge.
- R7: Clock-select codes 8 to 15 select the external clock. Shifting follows sck_in, sck_out stays high and sck_oe stays low.
- R8: The end of a frame sets status bit 6 and irq. Writing 1 to that bit leaves it set. Writing 0 clears it.
- R9: With the external clock, a rising edge on sck_in while no frame runs sets status bit 5. It does not change the data or the serial output. The flag clears when 0 is written to it.
- R10: While no frame runs, the serial output keeps the last bit sent. A status write sets it to the written bit 0. Status bit 0 reads the present output level.
- R11: Any control write stops a running frame, clears the bit counter and the start bit, and leaves the serial clock high with no completion flag. The next start runs a full frame.
- R12: Register reads: address 0 returns the control register, address 1 the status register, address 2 the low data byte and address 3 the high data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| irq | output | 1 | Transfer-complete request |

## Verification
The shifter is exercised with several frame types: byte frames with the fastest internal clock, word frames with a slower divider, and byte frames clocked from the pin. The transmit and receive patterns are asymmetric, so a reversed bit order, a swapped byte or a missing high byte produces a wrong value. Counting the low-phase cycles of the output clock tells the divider codes apart. Extra pin pulses after a frame separate correct overrun handling from stray shifting. A control write in the middle of a frame, followed by a fresh frame, shows that the counter restarts from zero.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int WORD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int SEL_W  = 4;
    localparam int RATE_W = SEL_W - 1;
    localparam int DIV_W  = (1 << RATE_W);

    localparam int B_WIDE  = 6;
    localparam int B_START = 7;
    localparam int B_DONE  = 6;
    localparam int B_OVR   = 5;
    localparam int B_LVL   = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DLO  = 2'd2,
        A_DHI  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             wide;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

    function automatic logic sel_is_ext(input logic [SEL_W-1:0] s);
        return s[SEL_W-1];
    endfunction

    function automatic logic [CNT_W-1:0] frame_bits(input logic wide);
        return wide ? CNT_W'(WORD_W) : CNT_W'(WORD_W / 2);
    endfunction

endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen
    import ssx_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [RW-1:0] rate,
    output logic          sck,
    output edge_t         stb
);

    logic [DW-1:0] cnt;
    logic [DW-1:0] lim;
    logic          at_lim;

    always_comb begin
        lim      = (DW'(1) << rate) - DW'(1);
        at_lim   = (cnt == lim);
        stb.fall = run && at_lim && sck;
        stb.rise = run && at_lim && !sck;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (at_lim) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + DW'(1);
        end
    end

    // R5: the generated clock is high in every cycle that follows an idle cycle
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !run |=> sck);

endmodule

// File: rtl/ssx_sync_edge.sv
module ssx_sync_edge
    import ssx_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t stb
);

    logic [SYNC_N:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[SYNC_N-1:0], pin};
    end

    always_comb begin
        stb.rise = sh[SYNC_N-1] & ~sh[SYNC_N];
        stb.fall = ~sh[SYNC_N-1] & sh[SYNC_N];
    end

endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter
    import ssx_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              go,
    input  logic              wide,
    input  edge_t             stb,
    input  logic              si,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [W/2-1:0]    wdata,
    input  logic              lvl_wr,
    input  logic              lvl_val,
    output logic              busy,
    output logic [W-1:0]      word,
    output logic              so,
    output logic              done_pulse
);

    localparam int HALF = W / 2;

    logic [CW-1:0] nbit;
    logic [CW-1:0] total;

    always_comb begin
        total      = wide ? CW'(W) : CW'(HALF);
        done_pulse = busy && stb.rise && (nbit == total - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            nbit <= '0;
            word <= '0;
            so   <= 1'b1;
        end else begin
            if (abort) begin
                busy <= 1'b0;
                nbit <= '0;
            end else if (go && !busy) begin
                busy <= 1'b1;
                nbit <= '0;
            end else if (busy && stb.fall) begin
                so <= word[0];
            end else if (busy && stb.rise) begin
                if (wide) word <= {si, word[W-1:1]};
                else      word[HALF-1:0] <= {si, word[HALF-1:1]};
                nbit <= nbit + CW'(1);
                if (nbit == total - CW'(1)) busy <= 1'b0;
            end
            if (!busy) begin
                if (wr_lo)  word[HALF-1:0] <= wdata;
                if (wr_hi)  word[W-1:HALF] <= wdata;
                if (lvl_wr) so <= lvl_val;
            end
        end
    end

    // R1: the bit counter never passes the frame length
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (nbit < total));

    // R10: while stopped the output moves only through a level write
    a_r10_so_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(lvl_wr)) |-> $stable(so));

endmodule

// File: rtl/ssx_top.sv
module ssx_top
    import ssx_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              so,
    input  logic              si,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic              done_q;
    logic              ovr_q;
    logic              wr_ctrl, wr_stat, wr_lo, wr_hi;
    logic              ext;
    logic              busy;
    logic              done_pulse;
    logic [WORD_W-1:0] word;
    edge_t             int_stb, ext_stb, sel_stb;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr_e'(reg_addr) == A_CTRL);
        wr_stat = reg_we && (reg_addr_e'(reg_addr) == A_STAT);
        wr_lo   = reg_we && (reg_addr_e'(reg_addr) == A_DLO);
        wr_hi   = reg_we && (reg_addr_e'(reg_addr) == A_DHI);
        ext     = sel_is_ext(ctrl_q.sel);
        sel_stb = ext ? ext_stb : int_stb;
    end

    ssx_clkgen u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && !ext),
        .rate (ctrl_q.sel[RATE_W-1:0]),
        .sck  (sck_out),
        .stb  (int_stb)
    );

    ssx_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (sck_in),
        .stb (ext_stb)
    );

    ssx_shifter u_shf (
        .clk        (clk),
        .rst        (rst),
        .abort      (wr_ctrl),
        .go         (wr_stat && reg_wdata[B_START]),
        .wide       (ctrl_q.wide),
        .stb        (sel_stb),
        .si         (si),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (reg_wdata),
        .lvl_wr     (wr_stat),
        .lvl_val    (reg_wdata[B_LVL]),
        .busy       (busy),
        .word       (word),
        .so         (so),
        .done_pulse (done_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.wide <= reg_wdata[B_WIDE];
                ctrl_q.sel  <= reg_wdata[SEL_W-1:0];
            end
            if (wr_stat) begin
                done_q <= done_q & reg_wdata[B_DONE];
                ovr_q  <= ovr_q & reg_wdata[B_OVR];
            end
            if (done_pulse)                  done_q <= 1'b1;
            if (ext && !busy && ext_stb.rise) ovr_q  <= 1'b1;
        end
    end

    always_comb begin
        sck_oe = busy && !ext;
        irq    = done_q;
        unique case (reg_addr_e'(reg_addr))
            A_CTRL:  reg_rdata = {1'b0, ctrl_q.wide, 2'b00, ctrl_q.sel};
            A_STAT:  reg_rdata = {busy, done_q, ovr_q, 4'b0000, so};
            A_DLO:   reg_rdata = word[DATA_W-1:0];
            default: reg_rdata = word[WORD_W-1:DATA_W];
        endcase
    end

    // R8: the completion flag rises only at the end of a running frame
    a_r8_done_src: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(busy));

    // R9: overrun rises only for a pin edge with no frame under way
    a_r9_ovr_src: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(ext && !busy));

    // R4: a frame begins only from a start write
    a_r4_start_src: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_stat && reg_wdata[B_START]));

    // R11: a control write always leaves the shifter stopped
    a_r11_abort: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> !busy);

endmodule

// File: tb/sim_ssx_top.sv
module sim_ssx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, so, irq;
    logic       si = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit tb_ext = 1'b0;
    bit mon_en = 1'b0;
    bit ended = 1'b0;
    int edge_cnt = 0;
    int low_cnt = 0;
    int oe_cnt = 0;
    logic exp_so[$];
    logic si_q[$];
    logic mon_line;

    always #10 clk = ~clk;

    assign mon_line = tb_ext ? sck_in : sck_out;

    ssx_top u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .so(so), .si(si), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected serial output bits at each rising serial clock
    initial forever begin
        @(posedge mon_line);
        edge_cnt++;
        @(negedge clk);
        if (mon_en) begin
            if (exp_so.size() > 0) chk("R2/R6 so bit", so, exp_so.pop_front());
            else chk("R1 unexpected clock pulse", 1, 0);
        end
    end

    // serial input driver: next bit after each falling serial clock
    initial forever begin
        @(negedge mon_line);
        @(negedge clk);
        if (si_q.size() > 0) si = si_q.pop_front();
    end

    always @(negedge clk) begin
        if (!sck_out) low_cnt++;
        if (sck_oe) oe_cnt++;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd1, s);
            if (!s[7]) break;
        end
    endtask

    task automatic ext_pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            sck_in = 1'b0;
            repeat (half) @(negedge clk);
            sck_in = 1'b1;
            repeat (half) @(negedge clk);
        end
    endtask

    // driver: loads the frame, pushes expected bits, starts it and waits
    task automatic run_frame(input logic [7:0] c, input logic [15:0] tx,
                             input logic [15:0] rx, input int n, input bit ext);
        tb_ext = ext;
        wr(2'd0, c);
        wr(2'd2, tx[7:0]);
        wr(2'd3, tx[15:8]);
        for (int i = 0; i < n; i++) begin
            exp_so.push_back(tx[i]);
            si_q.push_back(rx[i]);
        end
        edge_cnt = 0; low_cnt = 0; oe_cnt = 0;
        mon_en = 1'b1;
        wr(2'd1, 8'h80);
        if (ext) ext_pulses(n, 6);
        wait_idle();
        repeat (2) @(negedge clk);
        mon_en = 1'b0;
        chk("R2 all bits seen", exp_so.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(2'd1, d); chk("R12 reset status", d, 8'h01);
        rd(2'd0, d); chk("R12 reset ctrl", d, 8'h00);
        chk("R5 reset sck high", sck_out, 1);
        chk("R5 reset oe low", sck_oe, 0);
        chk("R8 reset irq", irq, 0);

        // R4: no clock without a start
        e0 = edge_cnt;
        repeat (100) @(negedge clk);
        chk("R4 no clock before start", edge_cnt, e0);

        // byte frame, fastest internal clock
        run_frame(8'h00, 16'h77A5, 16'h003C, 8, 1'b0);
        rd(2'd2, d); chk("R3 rx low byte", d, 8'h3C);
        rd(2'd3, d); chk("R2 high byte untouched in 8-bit", d, 8'h77);
        rd(2'd1, d); chk("R4 R8 status after frame", d, 8'h41);
        chk("R8 irq set", irq, 1);
        chk("R1 eight pulses", edge_cnt, 8);
        chk("R5 code0 low time", low_cnt, 8);
        chk("R10 so holds bit7", so, 1);

        // flag handling and idle level
        wr(2'd1, 8'h40);
        rd(2'd1, d); chk("R8 R10 done kept, level 0", d, 8'h40);
        chk("R10 so forced low", so, 0);
        wr(2'd1, 8'h00);
        chk("R8 irq cleared", irq, 0);

        // word frame, divider code 3
        run_frame(8'h43, 16'h1234, 16'hBEEF, 16, 1'b0);
        rd(2'd2, d); chk("R3 rx low byte 16", d, 8'hEF);
        rd(2'd3, d); chk("R3 rx high byte 16", d, 8'hBE);
        rd(2'd0, d); chk("R12 ctrl readback", d, 8'h43);
        rd(2'd1, d); chk("R8 status after word", d, 8'h40);
        chk("R1 sixteen pulses", edge_cnt, 16);
        chk("R5 code3 low time", low_cnt, 128);
        chk("R5 oe during frame", oe_cnt > 0, 1);
        chk("R10 so holds bit15", so, 0);
        wr(2'd1, 8'h00);

        // byte frame on the external clock
        run_frame(8'h08, 16'h0096, 16'h005A, 8, 1'b1);
        rd(2'd2, d); chk("R7 ext rx byte", d, 8'h5A);
        chk("R7 sck_out stays high", low_cnt, 0);
        chk("R7 oe stays low", oe_cnt, 0);
        rd(2'd1, d); chk("R7 R8 ext status", d, 8'h41);

        // overrun pulses after the frame
        ext_pulses(2, 6);
        repeat (6) @(negedge clk);
        rd(2'd1, d); chk("R9 overrun set", d, 8'h61);
        rd(2'd2, d); chk("R9 data unchanged", d, 8'h5A);
        chk("R9 so unchanged", so, 1);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R9 overrun cleared", d, 8'h01);
        tb_ext = 1'b0;

        // abort in mid-frame
        wr(2'd0, 8'h05);
        wr(2'd2, 8'hF0);
        wr(2'd1, 8'h80);
        repeat (100) @(negedge clk);
        wr(2'd0, 8'h05);
        rd(2'd1, d); chk("R11 stopped by ctrl write", d[7:6], 2'b00);
        repeat (2) @(negedge clk);
        chk("R11 sck high after abort", sck_out, 1);
        e0 = edge_cnt;
        repeat (200) @(negedge clk);
        chk("R11 no pulses after abort", edge_cnt, e0);
        chk("R11 no irq after abort", irq, 0);
        si_q.delete();

        // fresh frame after abort runs in full
        run_frame(8'h01, 16'h00C3, 16'h0081, 8, 1'b0);
        rd(2'd2, d); chk("R11 full frame after abort", d, 8'h81);
        chk("R11 R1 pulses after abort", edge_cnt, 8);
        chk("R5 code1 low time", low_cnt, 16);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule